// File: doc/BRIEF.md
# Serial Converter Command and Readout Front End

This block is the digital serial side of an 8-bit multichannel converter. It runs on the system clock and watches three host lines that are already synchronous to that clock: an active-low select, a serial clock and a serial data input. While select is low, the block skips zeros until it sees a leading one. That one opens an 8-bit command, and the remaining seven bits follow it. On the serial-clock falling edge after the last command bit, the block issues a conversion-start pulse and latches the command fields.

The analog conversion itself is outside the block. It takes a fixed number of serial-clock falling edges (`CONV_FALLS`). During the last of those cycles a strobe is high. On the next falling edge the block captures the parallel result and starts shifting it out, most significant bit first, one bit per serial clock. A new command may begin on the first rising edge after the MSB has been driven, so the next command overlaps the readout. With the default busy time this gives a conversion every 10 serial clocks. Raising select abandons any command, conversion or readout in progress.

Top module: `sadc_serial_if`

## Requirements
- R1: After reset, `dout_en`, `dout`, `strobe` and `conv_start` are all 0.
- R2: While idle, zeros sampled on `din` at serial-clock rising edges are ignored. The command starts with the first one sampled, and that one becomes command bit 7.
- R3: A one-cycle `conv_start` pulse is issued on the serial-clock falling edge after the eighth command bit is sampled. At the same time the command fields are latched: bits 6:4 to `cmd_chan`, bit 3 to `cmd_unipolar`, bit 2 to `cmd_single`, bits 1:0 to `cmd_pwr`.
- R4: `strobe` goes high on falling edge 8+`CONV_FALLS`-1, counted from the first command bit (edge 9 by default). It stays high for exactly one serial-clock period and drops on the edge that presents the MSB.
- R5: On falling edge 8+`CONV_FALLS`, the value on `adc_result` is captured and its bit 7 is driven on `dout`. Bits 6 down to 0 follow on the next seven falling edges, with `dout_en` high for exactly those eight periods. `dout` changes only on falling edges.
- R6: Ones on `din` during the conversion, before the MSB has been driven, are ignored. They start no command and leave the latched fields unchanged.
- R7: A start bit sampled on the first rising edge after the MSB falling edge is accepted. This allows back-to-back conversions every 10 serial clocks, each with its own result.
- R8: While `cs_n` is high, the command, conversion and readout are abandoned: `dout_en` and `strobe` fall within one clock and no strobe or readout follows. After `cs_n` returns low, the next one sampled on `din` starts a fresh command.
- R9: A falling edge of `cs_n` on its own starts no command and no conversion.
- R10: `dout` is 0 whenever `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select, synchronous to clk |
| sclk | input | 1 | Serial clock, synchronous to clk |
| din | input | 1 | Serial command data, sampled on sclk rising edges |
| adc_result | input | RES_W | Parallel conversion result, captured at the MSB edge |
| dout | output | 1 | Serial result data, changed on sclk falling edges |
| dout_en | output | 1 | High while a result bit is being driven |
| strobe | output | 1 | One serial period high just before the MSB |
| conv_start | output | 1 | One-clock pulse that starts the conversion |
| cmd_chan | output | 3 | Latched channel select field |
| cmd_unipolar | output | 1 | Latched unipolar/bipolar field |
| cmd_single | output | 1 | Latched single-ended/differential field |
| cmd_pwr | output | 2 | Latched power field |

## Verification
The assertions assume that `sclk` and `cs_n` are already synchronous to `clk`, and that each serial-clock level lasts at least two system clocks. The stability check on `dout` depends on this, because it expects a change only on a clock that follows a serial-clock fall. The assertions also assume `cs_n` does not move in the same clock as a serial edge the checks depend on. The bench holds every serial half-period for several clocks and moves `din`, `cs_n` and `adc_result` only while `sclk` is low and away from its edges.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    localparam int CMD_W = 8;

    // Command layout, MSB first: start, channel, polarity, input type, power
    typedef struct packed {
        logic       start;
        logic [2:0] chan;
        logic       unipolar;
        logic       single;
        logic [1:0] pwr;
    } sadc_cmd_t;

    // Serial clock events, qualified by an active select
    typedef struct packed {
        logic sel;
        logic rise;
        logic fall;
    } sadc_ev_t;

    function automatic sadc_cmd_t sadc_unpack(input logic [CMD_W-1:0] raw);
        return sadc_cmd_t'(raw);
    endfunction

endpackage

// File: rtl/sadc_edge.sv
module sadc_edge
    import sadc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_n,
    input  logic     sclk,
    output sadc_ev_t ev
);

    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk;
    end

    always_comb begin
        ev.sel  = ~cs_n;
        ev.rise = ~cs_n &  sclk & ~sclk_q;
        ev.fall = ~cs_n & ~sclk &  sclk_q;
    end

endmodule

// File: rtl/sadc_cmd_rx.sv
module sadc_cmd_rx
    import sadc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  sadc_ev_t         ev,
    input  logic             din,
    input  logic             arm,
    output logic             cmd_done,
    output logic [CMD_W-1:0] cmd_raw
);

    localparam int CW = $clog2(CMD_W + 1);

    logic [CW-1:0]    cnt;
    logic [CMD_W-1:0] shreg;
    logic             armed;

    always_ff @(posedge clk) begin
        if (rst || !ev.sel) begin
            cnt   <= '0;
            shreg <= '0;
            armed <= 1'b1;
        end else begin
            if (arm) armed <= 1'b1;
            if (ev.rise) begin
                if (cnt == '0) begin
                    if (armed && din) begin
                        shreg <= {shreg[CMD_W-2:0], 1'b1};
                        cnt   <= CW'(1);
                        armed <= 1'b0;
                    end
                end else if (cnt < CW'(CMD_W)) begin
                    shreg <= {shreg[CMD_W-2:0], din};
                    cnt   <= cnt + CW'(1);
                end
            end
            if (ev.fall && cnt == CW'(CMD_W)) cnt <= '0;
        end
    end

    assign cmd_done = ev.fall && (cnt == CW'(CMD_W));
    assign cmd_raw  = shreg;

endmodule

// File: rtl/sadc_conv_seq.sv
module sadc_conv_seq
    import sadc_pkg::*;
#(
    parameter int RES_W      = 8,
    parameter int CONV_FALLS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  sadc_ev_t         ev,
    input  logic             cmd_done,
    input  logic [RES_W-1:0] adc_result,
    output logic             conv_start,
    output logic             strobe,
    output logic             arm,
    output logic             dout,
    output logic             dout_en
);

    localparam int BW = $clog2(CONV_FALLS + 2);
    localparam int TW = $clog2(RES_W + 1);

    logic [BW-1:0]    busy;
    logic [TW-1:0]    tx_left;
    logic [RES_W-1:0] tx_sh;

    always_ff @(posedge clk) begin
        if (rst || !ev.sel) begin
            busy       <= '0;
            strobe     <= 1'b0;
            tx_left    <= '0;
            tx_sh      <= '0;
            conv_start <= 1'b0;
            arm        <= 1'b0;
        end else begin
            conv_start <= 1'b0;
            arm        <= 1'b0;
            if (ev.fall) begin
                // result shifting
                if (tx_left > TW'(1)) begin
                    tx_sh   <= {tx_sh[RES_W-2:0], 1'b0};
                    tx_left <= tx_left - TW'(1);
                end else if (tx_left == TW'(1)) begin
                    tx_left <= '0;
                end
                // conversion timing
                if (cmd_done) begin
                    conv_start <= 1'b1;
                    busy       <= BW'(CONV_FALLS);
                    strobe     <= (CONV_FALLS == 1);
                end else if (busy > BW'(1)) begin
                    busy   <= busy - BW'(1);
                    strobe <= (busy == BW'(2));
                end else if (busy == BW'(1)) begin
                    busy    <= '0;
                    strobe  <= 1'b0;
                    tx_sh   <= adc_result;
                    tx_left <= TW'(RES_W);
                    arm     <= 1'b1;
                end
            end
        end
    end

    assign dout_en = (tx_left != '0);
    assign dout    = dout_en & tx_sh[RES_W-1];

endmodule

// File: rtl/sadc_serial_if.sv
module sadc_serial_if
    import sadc_pkg::*;
#(
    parameter int RES_W      = 8,
    parameter int CONV_FALLS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    input  logic [RES_W-1:0] adc_result,
    output logic             dout,
    output logic             dout_en,
    output logic             strobe,
    output logic             conv_start,
    output logic [2:0]       cmd_chan,
    output logic             cmd_unipolar,
    output logic             cmd_single,
    output logic [1:0]       cmd_pwr
);

    sadc_ev_t         ev;
    logic             cmd_done;
    logic             arm;
    logic [CMD_W-1:0] cmd_raw;
    sadc_cmd_t        cmd_q;

    sadc_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .sclk (sclk),
        .ev   (ev)
    );

    sadc_cmd_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .din      (din),
        .arm      (arm),
        .cmd_done (cmd_done),
        .cmd_raw  (cmd_raw)
    );

    sadc_conv_seq #(
        .RES_W      (RES_W),
        .CONV_FALLS (CONV_FALLS)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .cmd_done   (cmd_done),
        .adc_result (adc_result),
        .conv_start (conv_start),
        .strobe     (strobe),
        .arm        (arm),
        .dout       (dout),
        .dout_en    (dout_en)
    );

    always_ff @(posedge clk) begin
        if (rst)           cmd_q <= '0;
        else if (cmd_done) cmd_q <= sadc_unpack(cmd_raw);
    end

    assign cmd_chan     = cmd_q.chan;
    assign cmd_unipolar = cmd_q.unipolar;
    assign cmd_single   = cmd_q.single;
    assign cmd_pwr      = cmd_q.pwr;

endmodule

// File: rtl/sadc_serial_if_chk.sv
module sadc_serial_if_chk (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sclk,
    input logic dout,
    input logic dout_en,
    input logic strobe,
    input logic conv_start
);

    // R10: data line quiet when not driving a result
    p_dout_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !dout_en |-> !dout);

    // R8: select high clears strobe and readout
    p_cs_abort_r8: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (!dout_en && !strobe));

    // R3: start is a single-clock pulse
    p_start_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    // R4: strobe rises while serial clock is low
    p_strobe_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe) |-> !sclk);

    // R4, R5: readout begins exactly as strobe drops
    p_msb_after_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(dout_en) |-> $fell(strobe));

    // R5: no data change without a serial falling edge
    p_dout_stable_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(sclk) && !$past(cs_n) && !$past(rst)) |-> $stable(dout));

endmodule

bind sadc_serial_if sadc_serial_if_chk u_chk (.*);

// File: tb/tb_sadc_serial_if.sv
module tb_sadc_serial_if;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       din = 1'b0;
    logic [7:0] adc_result = '0;
    logic       dout, dout_en, strobe, conv_start;
    logic [2:0] cmd_chan;
    logic       cmd_unipolar, cmd_single;
    logic [1:0] cmd_pwr;

    int checks = 0;
    int errors = 0;
    int nconv  = 0;
    int idx    = 0;
    logic s_en [0:63];
    logic s_do [0:63];
    logic s_st [0:63];

    // lead zeros [19:16], command [15:8], result [7:0]
    localparam logic [19:0] VEC [4] = '{
        {4'd0, 8'h8F, 8'hA5},
        {4'd3, 8'hF2, 8'h3C},
        {4'd1, 8'hC4, 8'hFF},
        {4'd5, 8'hB9, 8'h01}
    };

    always #5 clk = ~clk;

    sadc_serial_if dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
        .adc_result(adc_result), .dout(dout), .dout_en(dout_en),
        .strobe(strobe), .conv_start(conv_start), .cmd_chan(cmd_chan),
        .cmd_unipolar(cmd_unipolar), .cmd_single(cmd_single), .cmd_pwr(cmd_pwr)
    );

    always @(posedge clk) if (conv_start) nconv++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic d);
        @(negedge clk); din = d;
        repeat (2) @(negedge clk); sclk = 1'b1;
        repeat (2) @(negedge clk);
        s_en[idx] = dout_en; s_do[idx] = dout; s_st[idx] = strobe;
        if (idx < 63) idx++;
        repeat (2) @(negedge clk); sclk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) tick(b[i]);
    endtask

    task automatic zeros(input int n);
        for (int i = 0; i < n; i++) tick(1'b0);
    endtask

    // base = sample index during which strobe must be high
    task automatic check_readout(input int base, input logic [7:0] res, input string req);
        chk(s_st[base] === 1'b1, {req, " strobe high"}, s_st[base], 1);
        chk(s_st[base-1] === 1'b0 && s_st[base+1] === 1'b0, {req, " strobe width"},
            {s_st[base-1], s_st[base+1]}, 0);
        chk(s_en[base] === 1'b0, {req, " enable before MSB"}, s_en[base], 0);
        for (int k = 0; k < 8; k++) begin
            chk(s_en[base+1+k] === 1'b1, {req, " enable during bit"}, s_en[base+1+k], 1);
            chk(s_do[base+1+k] === res[7-k], {req, " data bit"}, s_do[base+1+k], res[7-k]);
        end
        chk(s_en[base+9] === 1'b0, {req, " enable after B0"}, s_en[base+9], 0);
        chk(s_do[base+9] === 1'b0, "R10 dout low when idle", s_do[base+9], 0);
    endtask

    task automatic check_fields(input logic [7:0] c, input string req);
        chk({cmd_chan, cmd_unipolar, cmd_single, cmd_pwr} === c[6:0], req,
            {cmd_chan, cmd_unipolar, cmd_single, cmd_pwr}, c[6:0]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk(dout_en === 1'b0 && dout === 1'b0, "R1 readout idle", {dout_en, dout}, 0);
        chk(strobe === 1'b0 && conv_start === 1'b0, "R1 control idle", {strobe, conv_start}, 0);

        // R9: select falling alone starts nothing
        cs_n = 1'b0;
        idx = 0; n0 = nconv;
        zeros(20);
        chk(nconv == n0, "R9 no conversion from select", nconv - n0, 0);
        chk(s_en[19] === 1'b0 && s_st[19] === 1'b0, "R9 no readout", {s_en[19], s_st[19]}, 0);

        // R2, R3, R4, R5: vector table
        foreach (VEC[v]) begin
            idx = 0; n0 = nconv;
            adc_result = VEC[v][7:0];
            zeros(int'(VEC[v][19:16]));
            idx = 0;
            send_byte(VEC[v][15:8]);
            zeros(11);
            chk(nconv - n0 == 1, "R3 one start per command", nconv - n0, 1);
            check_fields(VEC[v][15:8], "R2 R3 fields after leading zeros");
            check_readout(9, VEC[v][7:0], "R4 R5 table readout");
        end

        // R6: ones during conversion are ignored
        idx = 0; n0 = nconv;
        adc_result = 8'h5E;
        send_byte(8'h9A);
        tick(1'b1); tick(1'b1);
        zeros(15);
        chk(nconv - n0 == 1, "R6 no extra start", nconv - n0, 1);
        check_fields(8'h9A, "R6 fields kept");
        check_readout(9, 8'h5E, "R6 readout intact");

        // R7: back-to-back every 10 serial clocks
        idx = 0; n0 = nconv;
        adc_result = 8'hC3;
        send_byte(8'hA1);
        zeros(2);
        tick(1'b1);
        adc_result = 8'h3E;
        send_byte({1'b1, 7'h56} << 1);
        zeros(11);
        chk(nconv - n0 == 2, "R7 two conversions", nconv - n0, 2);
        check_readout(9, 8'hC3, "R7 first readout");
        check_readout(19, 8'h3E, "R7 second readout");
        check_fields(8'hD6, "R7 second fields");

        // R8: abort during conversion
        idx = 0; n0 = nconv;
        adc_result = 8'h77;
        send_byte(8'hE0);
        @(negedge clk); cs_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(strobe === 1'b0 && dout_en === 1'b0, "R8 abort clears", {strobe, dout_en}, 0);
        cs_n = 1'b0;
        idx = 0;
        zeros(12);
        chk(s_st[1] === 1'b0 && s_en[2] === 1'b0 && s_en[9] === 1'b0,
            "R8 no strobe or readout after abort", {s_st[1], s_en[2], s_en[9]}, 0);
        chk(nconv - n0 == 1, "R8 aborted conversion count", nconv - n0, 1);

        // R8: fresh command after abort
        idx = 0; n0 = nconv;
        adc_result = 8'h69;
        send_byte(8'h85);
        zeros(11);
        chk(nconv - n0 == 1, "R8 restart conversion", nconv - n0, 1);
        check_fields(8'h85, "R8 restart fields");
        check_readout(9, 8'h69, "R8 restart readout");

        // R8, R10: abort during readout
        idx = 0;
        adc_result = 8'hFF;
        send_byte(8'hC0);
        zeros(5);
        chk(s_en[12] === 1'b1, "R8 readout running", s_en[12], 1);
        @(negedge clk); cs_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(dout_en === 1'b0, "R8 readout aborted", dout_en, 0);
        chk(dout === 1'b0, "R10 dout low after abort", dout, 0);
        cs_n = 1'b0;
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule